// File: doc/BRIEF.md
# I2C SCL Phase Timing Generator

This block turns programmed timing fields into the bit-level clock pattern of an I2C controller. A free-running internal divider reduces the source clock. Each tick of that divider feeds a sample prescaler. Sample ticks are then counted to form the SCL low phase and the SCL high phase. The two phase counts are programmed separately, so the duty cycle can be uneven while the full period stays as programmed. The programmed values for the divider, the prescaler and the phase counts are all stored minus one.

The transaction sequencer starts the generator with a one-cycle `run` request and halts it with a one-cycle `stop` request. An optional START setup interval holds SCL high for a count of raw source clocks before the first low phase. During each low phase the block gives the sequencer one strobe at a programmed point, where SDA may change. During each high phase it gives one strobe in the middle, where SDA should be sampled. It also pulses `phase_done` in the last cycle of every phase. The block does not compute divider values; software chooses them.

Top module: `scl_phase_gen`

## Requirements
- R1: After reset and while idle, `scl` is 1 and `sda_upd`, `sda_smp` and `phase_done` are 0.
- R2: Each SCL low phase lasts (low_cnt+1)·(sample_m1+1)·(clk_div_m1+1) source clock cycles.
- R3: Each SCL high phase between two low phases lasts (high_cnt+1)·(sample_m1+1)·(clk_div_m1+1) source clock cycles.
- R4: When `run` is captured in idle with `sta_en`=1, `scl` stays 1 for exactly sta_len_m1+1 further cycles (up to 256) before the first low phase. With `sta_en`=0 the low phase starts at the capturing edge.
- R5: `sda_upd` pulses exactly once per low phase, provided that sda_point ≤ low_cnt. The pulse comes in cycle (sda_point+1)·(sample_m1+1)·(clk_div_m1+1) of that phase, counted from 1.
- R6: `sda_smp` pulses exactly once per high phase, in cycle (floor(high_cnt/2)+1)·(sample_m1+1)·(clk_div_m1+1), counted from 1.
- R7: `phase_done` is high for one cycle in the last cycle of every low and every high phase. After a low phase ends, `scl` rises at the next edge.
- R8: A `stop` request takes the generator back to idle at the end of the next high phase to finish. That is either the high phase in progress or the one after the current low phase. `scl` is left at 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | One-cycle start request, honoured in idle |
| stop | input | 1 | One-cycle halt request |
| clk_div_m1 | input | DIV_W | Internal clock divider minus one |
| sample_m1 | input | SMP_W | Divided clocks per sample tick, minus one |
| high_cnt | input | CNT_W | Sample ticks in the high phase, minus one |
| low_cnt | input | CNT_W | Sample ticks in the low phase, minus one |
| sda_point | input | CNT_W | Sample tick in the low phase at which SDA may change |
| sta_en | input | 1 | Enables the START setup interval |
| sta_len_m1 | input | STA_W | START setup length in source clocks, minus one |
| scl | output | 1 | SCL level |
| sda_upd | output | 1 | SDA change strobe |
| sda_smp | output | 1 | SDA sample strobe |
| phase_done | output | 1 | Last cycle of a low or high phase |

## Verification
The bench sweeps every combination of divider 1..3 and prescaler 1..3 against several high and low counts, including the 1-tick extremes. This separates mistakes in each of the three multiplied terms, because a factor applied at the wrong level only matches when the other terms are 1. The SDA change point moves across the low phase from the first tick to the last. This exposes off-by-one errors in the compare and a strobe that lands on the wrong phase. START setup runs on alternate settings and once at its 256-clock limit; the other settings skip it. Each setting ends with a stop request, which shows whether the generator halts after a complete high phase and not mid-phase.

// File: rtl/scl_tg_pkg.sv
package scl_tg_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SETUP = 2'd1,
    ST_LOW   = 2'd2,
    ST_HIGH  = 2'd3
  } tg_state_t;

  // Sample tick inside the high phase at which SDA is sampled (floor of half).
  function automatic logic [15:0] mid_tick(input logic [15:0] cnt);
    return cnt >> 1;
  endfunction

  // Length of a phase in source clocks for the given stored-minus-one values.
  function automatic int unsigned phase_clocks(input int unsigned cnt,
                                               input int unsigned smp,
                                               input int unsigned div);
    return (cnt + 1) * (smp + 1) * (div + 1);
  endfunction

endpackage

// File: rtl/scl_tg_modcnt.sv
module scl_tg_modcnt #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  input  logic [W-1:0] lim,
  output logic [W-1:0] cnt,
  output logic         tick
);

  assign tick = en && (cnt == lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (clr)    cnt <= '0;
    else if (tick)   cnt <= '0;
    else if (en)     cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/scl_phase_gen.sv
module scl_phase_gen #(
  parameter int DIV_W = 4,
  parameter int SMP_W = 4,
  parameter int CNT_W = 6,
  parameter int STA_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             stop,
  input  logic [DIV_W-1:0] clk_div_m1,
  input  logic [SMP_W-1:0] sample_m1,
  input  logic [CNT_W-1:0] high_cnt,
  input  logic [CNT_W-1:0] low_cnt,
  input  logic [CNT_W-1:0] sda_point,
  input  logic             sta_en,
  input  logic [STA_W-1:0] sta_len_m1,
  output logic             scl,
  output logic             sda_upd,
  output logic             sda_smp,
  output logic             phase_done
);
  import scl_tg_pkg::*;

  localparam int MIDW = 16;

  tg_state_t state_q, state_d;
  logic stop_q;

  // Named internal events, used by the bound checker.
  logic idle_w, setup_w, low_w, high_w, active_w;
  logic div_tick, smp_tick, ph_end, setup_end;
  logic [DIV_W-1:0] div_cnt;
  logic [SMP_W-1:0] smp_cnt;
  logic [CNT_W-1:0] ph_cnt, ph_lim, mid_pt;
  logic [STA_W-1:0] sta_cnt;
  logic [MIDW-1:0]  mid_full;

  assign idle_w   = (state_q == ST_IDLE);
  assign setup_w  = (state_q == ST_SETUP);
  assign low_w    = (state_q == ST_LOW);
  assign high_w   = (state_q == ST_HIGH);
  assign active_w = low_w || high_w;

  scl_tg_modcnt #(.W(STA_W)) u_setup (
    .clk(clk), .rst_n(rst_n), .clr(!setup_w), .en(setup_w),
    .lim(sta_len_m1), .cnt(sta_cnt), .tick(setup_end)
  );

  scl_tg_modcnt #(.W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .clr(!active_w), .en(active_w),
    .lim(clk_div_m1), .cnt(div_cnt), .tick(div_tick)
  );

  scl_tg_modcnt #(.W(SMP_W)) u_smp (
    .clk(clk), .rst_n(rst_n), .clr(!active_w), .en(div_tick),
    .lim(sample_m1), .cnt(smp_cnt), .tick(smp_tick)
  );

  assign ph_lim = low_w ? low_cnt : high_cnt;

  scl_tg_modcnt #(.W(CNT_W)) u_phase (
    .clk(clk), .rst_n(rst_n), .clr(!active_w), .en(smp_tick),
    .lim(ph_lim), .cnt(ph_cnt), .tick(ph_end)
  );

  assign mid_full = mid_tick(MIDW'(high_cnt));
  assign mid_pt   = mid_full[CNT_W-1:0];

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (run) state_d = sta_en ? ST_SETUP : ST_LOW;
      ST_SETUP: if (setup_end) state_d = ST_LOW;
      ST_LOW:   if (ph_end) state_d = ST_HIGH;
      ST_HIGH:  if (ph_end) state_d = (stop_q || stop) ? ST_IDLE : ST_LOW;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      stop_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_d == ST_IDLE)  stop_q <= 1'b0;
      else if (stop && !idle_w) stop_q <= 1'b1;
    end
  end

  assign scl        = !low_w;
  assign phase_done = ph_end;
  assign sda_upd    = low_w && smp_tick && (ph_cnt == sda_point);
  assign sda_smp    = high_w && smp_tick && (ph_cnt == mid_pt);

endmodule

// File: rtl/scl_phase_gen_chk.sv
module scl_phase_gen_chk (
  input logic clk,
  input logic rst_n,
  input logic scl,
  input logic sda_upd,
  input logic sda_smp,
  input logic phase_done,
  input logic idle_w,
  input logic setup_w,
  input logic active_w
);

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    idle_w |-> (scl && !sda_upd && !sda_smp && !phase_done));

  p_low_end_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_done && !scl) |=> scl);

  p_rise_after_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl) |-> $past(phase_done));

  p_setup_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
    setup_w |-> (scl && !phase_done));

  p_upd_in_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sda_upd |-> !scl);

  p_smp_in_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sda_smp |-> (scl && active_w));

  p_done_active_r7: assert property (@(posedge clk) disable iff (!rst_n)
    phase_done |-> active_w);

endmodule

bind scl_phase_gen scl_phase_gen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl(scl), .sda_upd(sda_upd), .sda_smp(sda_smp),
  .phase_done(phase_done), .idle_w(idle_w), .setup_w(setup_w), .active_w(active_w)
);

// File: tb/scl_phase_gen_tb.sv
`timescale 1ns/1ps
module scl_phase_gen_tb;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run = 1'b0, stop = 1'b0;
  logic [3:0] clk_div_m1 = '0, sample_m1 = '0;
  logic [5:0] high_cnt = '0, low_cnt = '0, sda_point = '0;
  logic sta_en = 1'b0;
  logic [7:0] sta_len_m1 = '0;
  logic scl, sda_upd, sda_smp, phase_done;

  always #2 clk = ~clk;

  scl_phase_gen u_dut (
    .clk(clk), .rst_n(rst_n), .run(run), .stop(stop),
    .clk_div_m1(clk_div_m1), .sample_m1(sample_m1),
    .high_cnt(high_cnt), .low_cnt(low_cnt), .sda_point(sda_point),
    .sta_en(sta_en), .sta_len_m1(sta_len_m1),
    .scl(scl), .sda_upd(sda_upd), .sda_smp(sda_smp), .phase_done(phase_done)
  );

  int n_tests = 0, n_fail = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Monitor state
  int pos = 0, n_low = 0, n_high = 0;
  int low_bad = 0, low_badv = 0, high_bad = 0, high_badv = 0;
  int upd_n = 0, upd_bad = 0, upd_badv = 0;
  int smp_n = 0, smp_bad = 0, smp_badv = 0;
  int pd_n = 0, pd_bad = 0, pd_badv = 0;
  int e_low = 0, e_high = 0, e_upd = 0, e_smp = 0;
  bit seen_low = 0;
  logic prev_scl = 1'b1;

  always @(negedge clk) begin
    if (rst_n) begin
      if (scl !== prev_scl) begin
        if (prev_scl == 1'b0) begin
          n_low++;
          if (pos != e_low) begin low_bad++; low_badv = pos; end
        end else if (seen_low) begin
          n_high++;
          if (pos != e_high) begin high_bad++; high_badv = pos; end
        end
        if (scl == 1'b0) seen_low = 1;
        pos = 1;
      end else begin
        pos++;
      end
      prev_scl = scl;
      if (sda_upd) begin
        upd_n++;
        if (scl !== 1'b0 || pos != e_upd) begin upd_bad++; upd_badv = pos; end
      end
      if (sda_smp) begin
        smp_n++;
        if (scl !== 1'b1 || pos != e_smp) begin smp_bad++; smp_badv = pos; end
      end
      if (phase_done) begin
        pd_n++;
        if (pos != (scl ? e_high : e_low)) begin pd_bad++; pd_badv = pos; end
      end
    end
  end

  task automatic run_cfg(input int d, input int s, input int h, input int l,
                         input int p, input bit se, input int sl);
    int t, setup_seen, wait_cyc, n_at_stop, n_after;
    t = (s + 1) * (d + 1);
    @(negedge clk); #1;
    clk_div_m1 = 4'(d); sample_m1 = 4'(s); high_cnt = 6'(h); low_cnt = 6'(l);
    sda_point = 6'(p); sta_en = se; sta_len_m1 = 8'(sl);
    e_low = (l + 1) * t; e_high = (h + 1) * t;
    e_upd = (p + 1) * t; e_smp = (h / 2 + 1) * t;
    n_low = 0; n_high = 0; low_bad = 0; high_bad = 0; upd_n = 0; upd_bad = 0;
    smp_n = 0; smp_bad = 0; pd_n = 0; pd_bad = 0; seen_low = 0;
    run = 1'b1;
    @(negedge clk); #1;
    run = 1'b0;
    setup_seen = 0;
    while (scl && setup_seen < 400) begin
      setup_seen++;
      @(negedge clk); #1;
    end
    // R4: START setup length in raw clocks
    chk(setup_seen == (se ? sl + 1 : 0), "R4 setup", setup_seen, se ? sl + 1 : 0);
    while (n_low < 3) begin @(negedge clk); #1; end
    stop = 1'b1;
    n_at_stop = n_low;
    @(negedge clk); #1;
    stop = 1'b0;
    wait_cyc = 3 * (e_low + e_high) + 10;
    repeat (wait_cyc) @(negedge clk);
    #1;
    n_after = n_low;
    repeat (e_low + e_high + 4) @(negedge clk);
    #1;
    // R8: back to idle after at most one further low phase, SCL high
    chk(scl === 1'b1 && n_low == n_after && (n_low - n_at_stop) <= 1,
        "R8 stop to idle", n_low - n_at_stop, 1);
    // R2: low length
    chk(low_bad == 0 && n_low >= 3, "R2 low length", low_bad ? low_badv : n_low, e_low);
    // R3: high length
    chk(high_bad == 0 && n_high >= 2, "R3 high length", high_bad ? high_badv : n_high, e_high);
    // R5: one SDA change strobe per low at the programmed point
    chk(upd_bad == 0 && upd_n == n_low, "R5 sda_upd", upd_bad ? upd_badv : upd_n,
        upd_bad ? e_upd : n_low);
    // R6: one SDA sample strobe per high, at the middle tick
    chk(smp_bad == 0 && smp_n == n_low, "R6 sda_smp", smp_bad ? smp_badv : smp_n,
        smp_bad ? e_smp : n_low);
    // R7: phase_done on last cycle of every phase
    chk(pd_bad == 0 && pd_n == 2 * n_low, "R7 phase_done", pd_bad ? pd_badv : pd_n,
        pd_bad ? -1 : 2 * n_low);
    // R1: idle outputs quiet after stop
    chk(!sda_upd && !sda_smp && !phase_done, "R1 idle quiet",
        int'({sda_upd, sda_smp, phase_done}), 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int idx;
    int hv[3];
    int lv[3];
    hv = '{0, 1, 4};
    lv = '{0, 2, 5};
    repeat (3) @(negedge clk);
    // R1: reset values
    chk(scl === 1'b1 && !sda_upd && !sda_smp && !phase_done, "R1 reset",
        int'({scl, sda_upd, sda_smp, phase_done}), 8);
    #1 rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(scl === 1'b1 && !phase_done, "R1 idle after reset", int'(scl), 1);
    idx = 0;
    for (int d = 0; d < 3; d++)
      for (int s = 0; s < 3; s++)
        for (int hi = 0; hi < 3; hi++)
          for (int li = 0; li < 3; li++) begin
            run_cfg(d, s, hv[hi], lv[li], idx % (lv[li] + 1), idx[0], (idx * 7) % 40);
            idx++;
          end
    // R4 at its limit of 256 clocks
    run_cfg(1, 2, 3, 4, 4, 1'b1, 255);
    run_cfg(0, 0, 0, 0, 0, 1'b1, 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule